// File: doc/BRIEF.md
# Framed CRC-16 Byte Stream Checksum Unit

This unit sits in the byte path of a packet modem. It computes a 16-bit cyclic checksum over bytes and frames that calculation with a single control level called the checksum enable. In transmit it passes the outgoing byte stream through to the output port. It folds each byte into the checksum while the enable is high. When the enable drops, it appends the two complemented checksum bytes to the stream, and the input is held off while those two bytes go out.

In receive, the unit absorbs each incoming byte. One clock after each byte it reports whether the register now holds the fixed residue that a correct message plus its two checksum bytes leaves behind. It has no notion of message length, so software picks the flag reading that follows the second checksum byte. The receive calculation restarts at the next received byte after either a rising edge of the enable or a pulse from an external sync-word detector. Clearing the enable during reception has no effect.

The checksum uses polynomial 0x1021 with an all-ones start value. Each byte is fed most significant bit first.

Top module: `crc_frame_unit`

## Requirements
- R1: After a synchronous reset, sum_ok and sum_upd are 0 and no append is pending, so in tx mode out_valid follows in_valid. The checksum register holds 0xFFFF. A received pair 0x00,0x00 with no restart therefore leaves residue 0x1D0F.
- R2: In tx mode with no append in progress, out_valid equals in_valid, out_data equals in_data and in_ready equals out_ready. A byte transfers when in_valid and out_ready are both 1.
- R3: In tx mode, a byte that transfers in a cycle where sum_en is 1 is folded into the CRC register, MSB first, with polynomial 0x1021. A rising edge of sum_en reloads 0xFFFF before any byte of that same cycle is folded in. A byte that transfers while sum_en is 0 leaves the register unchanged.
- R4: In tx mode, the clock edge that follows a cycle in which sum_en fell starts an append. The unit then presents the bitwise complement of the register, high byte first and then low byte. Each byte stays valid and stable until out_ready is 1. in_ready is 0 for the whole append, and the appended bytes are not folded into the register.
- R5: In rx mode (rx_mode=1), in_ready is 1 outside an append. One cycle after each received byte, sum_ok is 1 exactly when the register after that byte equals 0x1D0F.
- R6: sum_upd is 1 for exactly the one cycle that follows each received byte, and is 0 at all other times.
- R7: In rx mode, a rising edge of sum_en makes the next received byte start from 0xFFFF. This includes a byte received in the same cycle as the edge.
- R8: In rx mode, a one-cycle sync_pulse makes the next received byte start from 0xFFFF. This includes a byte received in the same cycle as the pulse.
- R9: In rx mode, clearing sum_en in the middle of a message leaves the accumulation and the sum_ok result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_mode | input | 1 | 1 selects receive, 0 selects transmit |
| sum_en | input | 1 | Checksum enable level; its edges frame the calculation |
| sync_pulse | input | 1 | One-cycle pulse from the sync-word detector (receive restart) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Unit accepts the input byte |
| out_valid | output | 1 | Output byte valid (transmit) |
| out_data | output | 8 | Output byte: passed-through data or appended checksum |
| out_ready | input | 1 | Downstream accepts the output byte |
| sum_ok | output | 1 | Receive checksum flag: register holds the residue |
| sum_upd | output | 1 | One-cycle strobe marking a sum_ok update |

## Verification
The bench builds the unit with its default parameters: polynomial 0x1021, start value 0xFFFF and residue 0x1D0F. The bench models that polynomial as an explicit tap-position shift register, so its reference does not share the design's multiply-by-polynomial form. With these values the tests reach several paths: a full transmit-then-receive loop, where the appended bytes come back as a correct residue; a deliberately corrupted trailer; single-byte frames; and appends stalled by output back-pressure. They also cover restarts that land in the same cycle as a byte.

// File: rtl/crc_frame_pkg.sv
`timescale 1ns/1ps
package crc_frame_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CRC_W-1:0]  crc_t;

  typedef enum logic [1:0] {TX_PASS, TX_HI, TX_LO} tx_state_e;

  // Fold one byte into the register, MSB first, multiplying by poly.
  function automatic crc_t crc_step(crc_t cur, byte_t din, crc_t poly);
    crc_t c;
    logic fb;
    c = cur;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ din[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc_edge_detect.sv
`timescale 1ns/1ps
module crc_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/crc_accum.sv
`timescale 1ns/1ps
module crc_accum
  import crc_frame_pkg::*;
#(
  parameter crc_t POLY = 16'h1021,
  parameter crc_t INIT = 16'hFFFF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  logic  upd,
  input  byte_t din,
  output crc_t  crc_q,
  output crc_t  crc_next
);
  crc_t base;

  always_comb begin
    base     = restart ? INIT : crc_q;
    crc_next = upd ? crc_step(base, din, POLY) : base;
  end

  always_ff @(posedge clk) begin
    if (rst)                  crc_q <= INIT;
    else if (restart || upd)  crc_q <= crc_next;
  end
endmodule

// File: rtl/crc_tx_framer.sv
`timescale 1ns/1ps
module crc_tx_framer
  import crc_frame_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  out_ready,
  input  crc_t  crc,
  output logic  busy,
  output byte_t tx_byte
);
  tx_state_e state_q;
  crc_t      hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_PASS;
      hold_q  <= '0;
    end else begin
      case (state_q)
        TX_PASS: if (start) begin
          state_q <= TX_HI;
          hold_q  <= crc;
        end
        TX_HI:   if (out_ready) state_q <= TX_LO;
        TX_LO:   if (out_ready) state_q <= TX_PASS;
        default: state_q <= TX_PASS;
      endcase
    end
  end

  assign busy    = (state_q != TX_PASS);
  assign tx_byte = (state_q == TX_HI) ? ~hold_q[CRC_W-1 -: BYTE_W]
                                      : ~hold_q[BYTE_W-1:0];
endmodule

// File: rtl/crc_rx_checker.sv
`timescale 1ns/1ps
module crc_rx_checker
  import crc_frame_pkg::*;
#(
  parameter crc_t RESIDUE = 16'h1D0F
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_byte,
  input  logic restart_req,
  input  crc_t crc_next,
  output logic restart_now,
  output logic sum_ok,
  output logic sum_upd
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)              pend_q <= 1'b0;
    else if (rx_byte)     pend_q <= 1'b0;
    else if (restart_req) pend_q <= 1'b1;
  end

  assign restart_now = rx_byte & (restart_req | pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_ok  <= 1'b0;
      sum_upd <= 1'b0;
    end else begin
      sum_upd <= rx_byte;
      if (rx_byte) sum_ok <= (crc_next == RESIDUE);
    end
  end
endmodule

// File: rtl/crc_frame_unit.sv
`timescale 1ns/1ps
module crc_frame_unit
  import crc_frame_pkg::*;
#(
  parameter crc_t POLY    = 16'h1021,
  parameter crc_t INIT    = 16'hFFFF,
  parameter crc_t RESIDUE = 16'h1D0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_mode,
  input  logic              sum_en,
  input  logic              sync_pulse,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              sum_ok,
  output logic              sum_upd
);
  // Named internal events, observed by the bound checker.
  logic  en_rise, en_fall;
  logic  tx_busy;
  byte_t tx_byte;
  logic  xfer, rx_byte, tx_fold;
  logic  rx_restart;
  logic  acc_restart, acc_upd;
  crc_t  crc_q, crc_next;

  crc_edge_detect u_edge (
    .clk (clk), .rst (rst), .lvl (sum_en), .rise (en_rise), .fall (en_fall)
  );

  assign in_ready  = tx_busy ? 1'b0 : (rx_mode ? 1'b1 : out_ready);
  assign out_valid = tx_busy ? 1'b1 : (rx_mode ? 1'b0 : in_valid);
  assign out_data  = tx_busy ? tx_byte : (rx_mode ? '0 : in_data);

  assign xfer    = in_valid & in_ready;
  assign rx_byte = rx_mode & xfer;
  assign tx_fold = ~rx_mode & xfer & sum_en;

  assign acc_restart = rx_mode ? rx_restart : en_rise;
  assign acc_upd     = tx_fold | rx_byte;

  crc_accum #(.POLY(POLY), .INIT(INIT)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .restart  (acc_restart),
    .upd      (acc_upd),
    .din      (in_data),
    .crc_q    (crc_q),
    .crc_next (crc_next)
  );

  crc_tx_framer u_tx (
    .clk       (clk),
    .rst       (rst),
    .start     (~rx_mode & en_fall),
    .out_ready (out_ready),
    .crc       (crc_q),
    .busy      (tx_busy),
    .tx_byte   (tx_byte)
  );

  crc_rx_checker #(.RESIDUE(RESIDUE)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .rx_byte     (rx_byte),
    .restart_req (rx_mode & (en_rise | sync_pulse)),
    .crc_next    (crc_next),
    .restart_now (rx_restart),
    .sum_ok      (sum_ok),
    .sum_upd     (sum_upd)
  );
endmodule

// File: rtl/crc_frame_sva.sv
`timescale 1ns/1ps
module crc_frame_sva
  import crc_frame_pkg::*;
#(
  parameter crc_t INIT    = 16'hFFFF,
  parameter crc_t RESIDUE = 16'h1D0F
) (
  input logic  clk,
  input logic  rst,
  input logic  rx_mode,
  input logic  sum_en,
  input logic  out_ready,
  input logic  out_valid,
  input byte_t out_data,
  input logic  rx_byte,
  input logic  en_fall,
  input logic  tx_busy,
  input crc_t  crc_q,
  input logic  sum_ok,
  input logic  sum_upd
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (crc_q == INIT && !tx_busy && !sum_upd && !sum_ok)); // R1

  AST_TX_IDLE_HOLDS_REG: assert property (@(posedge clk) disable iff (rst)
    (!rx_mode && !sum_en) |=> $stable(crc_q)); // R3

  AST_FALL_STARTS_APPEND: assert property (@(posedge clk) disable iff (rst)
    (!rx_mode && en_fall && !tx_busy) |=> tx_busy); // R4

  AST_APPEND_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && !out_ready) |=> (out_valid && $stable(out_data))); // R4

  AST_FLAG_MATCHES_REG: assert property (@(posedge clk) disable iff (rst)
    sum_upd |-> (sum_ok == (crc_q == RESIDUE))); // R5

  AST_UPD_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    rx_byte |=> sum_upd); // R6

  AST_UPD_ONLY_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    sum_upd |-> $past(rx_byte)); // R6
endmodule

bind crc_frame_unit crc_frame_sva #(.INIT(INIT), .RESIDUE(RESIDUE)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .rx_mode   (rx_mode),
  .sum_en    (sum_en),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .rx_byte   (rx_byte),
  .en_fall   (en_fall),
  .tx_busy   (tx_busy),
  .crc_q     (crc_q),
  .sum_ok    (sum_ok),
  .sum_upd   (sum_upd)
);

// File: tb/sim_crc_frame_unit.sv
`timescale 1ns/1ps
module sim_crc_frame_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_mode = 1'b0, sum_en = 1'b0, sync_pulse = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, sum_ok, sum_upd;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  crc_frame_unit u0 (
    .clk (clk), .rst (rst), .rx_mode (rx_mode), .sum_en (sum_en),
    .sync_pulse (sync_pulse), .in_valid (in_valid), .in_data (in_data),
    .in_ready (in_ready), .out_valid (out_valid), .out_data (out_data),
    .out_ready (out_ready), .sum_ok (sum_ok), .sum_upd (sum_upd)
  );

  // Reference: shift register with taps at bit positions 0, 5 and 12.
  function automatic logic [15:0] ref_step(logic [15:0] c, logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:12], c[11] ^ fb, c[10:5], c[4] ^ fb, c[3:0], fb};
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_en(input logic v);
    sum_en = v; idle();
  endtask

  task automatic tx_send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b; out_ready = 1'b1;
    #1;
    check("R2 pass data", {8'h0, out_data}, {8'h0, b});
    check("R2 pass valid/ready", {14'h0, out_valid, in_ready}, 16'h3);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tx_collect(output logic [15:0] fcs);
    out_ready = 1'b1;
    check("R4 hi valid, input held", {14'h0, out_valid, in_ready}, 16'h2);
    fcs[15:8] = out_data;
    idle();
    check("R4 lo valid, input held", {14'h0, out_valid, in_ready}, 16'h2);
    fcs[7:0] = out_data;
    idle();
  endtask

  task automatic rx_send(input logic [7:0] b, output logic ok);
    in_valid = 1'b1; in_data = b;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R6 strobe after byte", {15'h0, sum_upd}, 16'h1);
    ok = sum_ok;
  endtask

  task automatic pulse_sync();
    sync_pulse = 1'b1; idle(); sync_pulse = 1'b0;
  endtask

  localparam int NV = 5;
  localparam logic [31:0] MSG [NV] = '{32'h31323334, 32'h00000000, 32'hFFFF0000,
                                       32'hA55AC300, 32'h12345678};
  localparam int          LEN [NV] = '{4, 1, 2, 3, 4};
  localparam bit          BAD [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r, fcs, h;
    logic ok;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();

    // R1: reset state at the ports
    check("R1 reset outputs", {12'h0, in_ready, out_valid, sum_ok, sum_upd}, 16'h8);
    // R1: register starts at 0xFFFF, so 00,00 lands on the residue
    rx_mode = 1'b1;
    rx_send(8'h00, ok);
    rx_send(8'h00, ok);
    check("R1 initial register", {15'h0, ok}, 16'h1);
    rx_mode = 1'b0; idle();

    // Table walk: transmit a frame, then receive it back with the trailer
    for (int v = 0; v < NV; v++) begin
      set_en(1'b1);
      r = 16'hFFFF;
      for (int k = 0; k < LEN[v]; k++) begin
        b = MSG[v][31 - 8*k -: 8];
        tx_send(b);
        r = ref_step(r, b);
      end
      set_en(1'b0);
      tx_collect(fcs);
      check("R3 R4 appended checksum", fcs, ~r);

      rx_mode = 1'b1;
      pulse_sync();
      r = 16'hFFFF;
      for (int k = 0; k < LEN[v]; k++) begin
        b = MSG[v][31 - 8*k -: 8];
        rx_send(b, ok);
        r = ref_step(r, b);
        check("R5 per-byte flag", {15'h0, ok}, {15'h0, (r == 16'h1D0F)});
      end
      rx_send(fcs[15:8], ok);
      r = ref_step(r, fcs[15:8]);
      check("R5 flag after hi", {15'h0, ok}, {15'h0, (r == 16'h1D0F)});
      rx_send(fcs[7:0] ^ {7'h0, BAD[v]}, ok);
      check("R5 final flag", {15'h0, ok}, {15'h0, !BAD[v]});
      idle();
      check("R6 strobe drops", {15'h0, sum_upd}, 16'h0);
      rx_mode = 1'b0; idle();
    end

    // R2: ready follows downstream in transmit
    out_ready = 1'b0; #1;
    check("R2 ready follows out_ready", {15'h0, in_ready}, 16'h0);
    out_ready = 1'b1; idle();

    // R3: byte sent with enable low is excluded
    tx_send(8'h77);
    set_en(1'b1);
    tx_send(8'h10);
    set_en(1'b0);
    tx_collect(fcs);
    check("R3 excluded byte", fcs, ~ref_step(16'hFFFF, 8'h10));

    // R3: rise and byte in the same cycle
    sum_en = 1'b1;
    tx_send(8'h5C);
    set_en(1'b0);
    tx_collect(fcs);
    check("R3 same-cycle rise", fcs, ~ref_step(16'hFFFF, 8'h5C));

    // R4: stalled append holds its byte and refuses input
    set_en(1'b1);
    tx_send(8'h42);
    set_en(1'b0);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 8'h99;
    h = {8'h0, out_data};
    for (int s = 0; s < 3; s++) begin
      idle();
      check("R4 stall stable", {7'h0, out_valid, out_data}, {7'h0, 1'b1, h[7:0]});
      check("R4 stall input held", {15'h0, in_ready}, 16'h0);
    end
    in_valid = 1'b0;
    tx_collect(fcs);
    check("R4 stalled checksum", fcs, ~ref_step(16'hFFFF, 8'h42));

    // R7: rising enable in receive restarts at the next byte
    r = ref_step(16'hFFFF, 8'h10);
    rx_mode = 1'b1;
    rx_send(8'hAB, ok);
    set_en(1'b1);
    rx_send(8'h10, ok);
    rx_send(~r[15:8], ok);
    rx_send(~r[7:0], ok);
    check("R7 restart on rise", {15'h0, ok}, 16'h1);

    // R9: clearing enable mid-message changes nothing
    pulse_sync();
    rx_send(8'h10, ok);
    set_en(1'b0);
    rx_send(~r[15:8], ok);
    rx_send(~r[7:0], ok);
    check("R9 clear enable mid-message", {15'h0, ok}, 16'h1);

    // R7: rise in the same cycle as the first byte
    rx_send(8'hCD, ok);
    sum_en = 1'b1;
    rx_send(8'h10, ok);
    rx_send(~r[15:8], ok);
    rx_send(~r[7:0], ok);
    check("R7 same-cycle rise", {15'h0, ok}, 16'h1);
    set_en(1'b0);

    // R8: sync pulse restart, pending and same-cycle
    rx_send(8'hAB, ok);
    pulse_sync();
    rx_send(8'h10, ok);
    rx_send(~r[15:8], ok);
    rx_send(~r[7:0], ok);
    check("R8 restart on sync", {15'h0, ok}, 16'h1);
    rx_send(8'hEE, ok);
    sync_pulse = 1'b1;
    rx_send(8'h10, ok);
    sync_pulse = 1'b0;
    rx_send(~r[15:8], ok);
    rx_send(~r[7:0], ok);
    check("R8 same-cycle sync", {15'h0, ok}, 16'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule